// File: doc/BRIEF.md
# I2C Channel Register Target

This block is an I2C target that holds eight 8-bit channel control bytes. A controller reads one of them in two separate bus transactions. First it writes a one-byte channel pointer and closes that transfer with a stop condition. Then a new read transaction returns the byte the pointer selects. Every channel needs its own pointer-write and read pair, because the pointer never advances by itself.

The bus pins use the open-drain model. SCL and SDA arrive as sampled inputs, and the block returns a pull-low enable for SDA. Both inputs pass through two-flop synchronizers into the system clock domain. All bus timing is derived from edges seen in that domain. Two strap inputs set the low two bits of the device address. A parallel port lets the surrounding logic write any channel byte and observe all eight bytes at once.

Top module: `i2c_chanreg_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits, sent MSB first, equal 0,1,0,1,1,A1,A0. A1 is `strap_a1_i` and A0 is `strap_a0_i`. The eighth bit is the direction: 0 for a pointer write, 1 for a read. The acknowledge is SDA held low for the ninth clock.
- R2: An address byte that does not match gets no acknowledge. The target then leaves SDA released and ignores all following bytes until the next start. The pointer is left unchanged.
- R3: In a pointer write, the byte after the address is acknowledged when its bits 7..3 are zero. Its bits 2..0 become the channel pointer.
- R4: A pointer byte with any of bits 7..3 set gets no acknowledge and leaves the pointer unchanged.
- R5: The pointer survives the stop that ends the write transaction. The next read transaction returns the selected channel byte, MSB first, right after the address acknowledge.
- R6: A read delivers exactly one byte. After its eighth bit the target releases SDA, even if the controller acknowledges and keeps clocking. After a stop, SDA is released and the target is idle.
- R7: The pointer does not auto-increment, so repeated reads return the same channel.
- R8: A start or stop seen in the middle of a byte abandons that transfer. Address reception then begins afresh with the next start.
- R9: The target changes its SDA drive only while SCL is low.
- R10: After reset the pointer and all channel bytes are zero and SDA is released. A read with no prior pointer write returns channel 0.
- R11: A write on the parallel port with `bank_wr_en_i` high stores `bank_wr_data_i` into the channel selected by `bank_wr_sel_i`. Channel n appears on `bank_q_o[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| strap_a1_i | input | 1 | Address strap, address bit 1 |
| strap_a0_i | input | 1 | Address strap, address bit 0 |
| bank_wr_en_i | input | 1 | Parallel channel write strobe |
| bank_wr_sel_i | input | 3 | Channel written by the parallel port |
| bank_wr_data_i | input | 8 | Byte written by the parallel port |
| bank_q_o | output | 64 | All channel bytes, channel n at bits 8n+7..8n |

## Verification
Several properties are checked on every cycle by assertions:
- SDA drive changes only while the synchronized SCL is low.
- Once the target has stopped listening, SDA stays released.
- The pointer changes only while a pointer byte is being received.
- The bit counter stays in range.
- Every stop returns the target to idle with SDA released.
- The channel bytes hold their values when the parallel port is not writing.

Other behaviours can only be shown by the bench scenarios, because each depends on a whole bus sequence:
- the address comparison against the straps;
- rejection of out-of-range pointer bytes;
- the pointer surviving the stop that ends its transaction;
- the MSB-first data value;
- the one-byte read limit;
- recovery from transfers abandoned mid-byte.

// File: rtl/chanreg_pkg.sv
package chanreg_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] DEV_ADDR_HI = 5'b01011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_TX,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/chanreg_sync.sv
module chanreg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/chanreg_bank.sv
module chanreg_bank #(
  parameter int NUM_CH = 8,
  localparam int PTR_W = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_sel,
  input  logic [7:0]             wr_data,
  input  logic [PTR_W-1:0]       rd_sel,
  output logic [7:0]             rd_data,
  output logic [NUM_CH*8-1:0]    bank_flat
);
  logic [7:0] regs_q [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic ch_we;
    assign ch_we = wr_en && (wr_sel == PTR_W'(ch));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[ch] <= '0;
      else if (ch_we) regs_q[ch] <= wr_data;
    end
    assign bank_flat[ch*8 +: 8] = regs_q[ch];
  end

  assign rd_data = regs_q[rd_sel];

  // R11: bytes only move when the parallel port writes
  p_bank_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_flat));
endmodule

// File: rtl/chanreg_proto.sv
module chanreg_proto
  import chanreg_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int PTR_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic [1:0]       addr_lo,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic             sda_pull
);
  tgt_state_e       state_q, state_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [6:0]       sh_q, sh_d;
  logic [7:0]       tx_q, tx_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             pull_q, pull_d;
  logic             rw_q, rw_d;
  logic             ackon_q, ackon_d;
  logic             scl_q, sda_q;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]       rx_byte;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign rx_byte   = {sh_q, sda_s};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    pull_d  = pull_q;
    rw_d    = rw_q;
    ackon_d = ackon_q;
    if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
      cnt_d   = '0;
      ackon_d = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      pull_d  = 1'b0;
      cnt_d   = '0;
      ackon_d = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_SUB: begin
          if (scl_rise) begin
            sh_d  = rx_byte[6:0];
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              cnt_d = '0;
              if (state_q == ST_ADDR) begin
                if (rx_byte[7:1] == {DEV_ADDR_HI, addr_lo}) begin
                  state_d = ST_ADDR_ACK;
                  rw_d    = rx_byte[0];
                end else begin
                  state_d = ST_IGNORE;
                end
              end else if (rx_byte[7:PTR_W] == '0) begin
                state_d = ST_SUB_ACK;
                ptr_d   = rx_byte[PTR_W-1:0];
              end else begin
                state_d = ST_IGNORE;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_SUB_ACK: begin
          if (scl_fall) begin
            if (!ackon_q) begin
              pull_d  = 1'b1;
              ackon_d = 1'b1;
            end else begin
              ackon_d = 1'b0;
              if (state_q == ST_ADDR_ACK && rw_q) begin
                state_d = ST_TX;
                pull_d  = ~rd_data[7];
                tx_d    = {rd_data[6:0], 1'b0};
              end else if (state_q == ST_ADDR_ACK) begin
                state_d = ST_SUB;
                pull_d  = 1'b0;
              end else begin
                state_d = ST_IGNORE;
                pull_d  = 1'b0;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              pull_d  = 1'b0;
              state_d = ST_IGNORE;
              cnt_d   = '0;
            end else begin
              pull_d = ~tx_q[7];
              tx_d   = {tx_q[6:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      ackon_q <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      pull_q  <= pull_d;
      rw_q    <= rw_d;
      ackon_q <= ackon_d;
      scl_q   <= scl_s;
      sda_q   <= sda_s;
    end
  end

  assign ptr      = ptr_q;
  assign sda_pull = pull_q;

  // R9: drive changes only follow an edge that saw SCL low
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !$past(scl_s));
  // R2: a target that stopped listening keeps SDA released
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !pull_q);
  // R4: pointer moves only while a pointer byte is received
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> ($past(state_q) == ST_SUB));
  // R6: a stop always leaves the target idle and released
  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !pull_q));
  // R8: the bit counter never runs past one byte plus acknowledge
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd8);
endmodule

// File: rtl/i2c_chanreg_target.sv
module i2c_chanreg_target #(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  input  logic                strap_a1_i,
  input  logic                strap_a0_i,
  input  logic                bank_wr_en_i,
  input  logic [PTR_W-1:0]    bank_wr_sel_i,
  input  logic [7:0]          bank_wr_data_i,
  output logic [NUM_CH*8-1:0] bank_q_o
);
  logic             rst_n_s;
  logic             scl_s, sda_s;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rd_data;

  chanreg_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s));

  chanreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n_s), .d(scl_i), .q(scl_s));

  chanreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n_s), .d(sda_i), .q(sda_s));

  chanreg_proto #(.NUM_CH(NUM_CH)) u_proto (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .addr_lo  ({strap_a1_i, strap_a0_i}),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .sda_pull (sda_pull_o)
  );

  chanreg_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (bank_wr_en_i),
    .wr_sel    (bank_wr_sel_i),
    .wr_data   (bank_wr_data_i),
    .rd_sel    (ptr),
    .rd_data   (rd_data),
    .bank_flat (bank_q_o)
  );
endmodule

// File: tb/tb_i2c_chanreg_target.sv
module tb_i2c_chanreg_target;
  localparam int H = 10;

  logic        clk = 1'b0;
  logic        rst_n, m_scl, m_sda, a1, a0, wen;
  logic [2:0]  wsel;
  logic [7:0]  wdat;
  logic        sda_pull;
  logic [63:0] bank;
  logic [7:0]  model [8];
  wire         sda_line = m_sda & ~sda_pull;
  int          checks = 0, errors = 0, viol = 0;
  logic        prev_pull = 1'b0, prev_scl = 1'b1;

  always #5 clk = ~clk;

  i2c_chanreg_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_a1_i(a1), .strap_a0_i(a0),
    .bank_wr_en_i(wen), .bank_wr_sel_i(wsel), .bank_wr_data_i(wdat),
    .bank_q_o(bank));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit addr_ok(input logic [6:0] a7, input logic s1, input logic s0);
    return a7 == {5'b01011, s1, s0};
  endfunction

  task automatic clock_bit(input logic b, output logic s);
    m_sda = b; hw(H);
    m_scl = 1'b1; hw(H);
    s = sda_line;
    m_scl = 1'b0; hw(H/2);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw(H);
    m_scl = 1'b1; hw(H);
    m_sda = 1'b0; hw(H);
    m_scl = 1'b0; hw(H/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw(H);
    m_scl = 1'b1; hw(H);
    m_sda = 1'b1; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clock_bit(mack ? 1'b0 : 1'b1, s);
  endtask

  task automatic set_ptr(input logic [7:0] sub, output bit aa, output bit as);
    bus_start();
    send_byte({5'b01011, a1, a0, 1'b0}, aa);
    as = 1'b0;
    if (aa) send_byte(sub, as);
    bus_stop();
  endtask

  task automatic read_one(output bit ra, output logic [7:0] d);
    bus_start();
    send_byte({5'b01011, a1, a0, 1'b1}, ra);
    d = 8'hFF;
    if (ra) recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic preload(input logic [2:0] ch, input logic [7:0] v);
    wen = 1'b1; wsel = ch; wdat = v;
    @(negedge clk);
    wen = 1'b0;
    @(negedge clk);
    model[ch] = v;
  endtask

  // R9 monitor: drive must not change while SCL is high on both sides
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && sda_pull !== prev_pull && prev_scl && m_scl) viol++;
      prev_pull = sda_pull;
      prev_scl  = m_scl;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit aa, as, ra;
    logic [7:0] d, d2;
    void'($urandom(32'd4711));
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; a1 = 1'b1; a0 = 1'b0;
    wen = 1'b0; wsel = '0; wdat = '0;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    hw(5); rst_n = 1'b1; hw(5);

    chk(sda_pull == 1'b0, "R10 sda released after reset", sda_pull, 0);
    chk(bank == 64'h0, "R10 bank zero after reset", bank, 0);

    preload(3'd0, 8'hA5);
    chk(bank[7:0] == 8'hA5, "R11 parallel write channel 0", bank[7:0], 8'hA5);
    read_one(ra, d);
    chk(ra, "R1 read address acknowledged", ra, 1);
    chk(d == 8'hA5, "R10 read without pointer write gives channel 0", d, 8'hA5);

    for (int i = 0; i < 8; i++) preload(3'(i), 8'($urandom));
    chk(bank[47:40] == model[5], "R11 channel 5 on bank port", bank[47:40], model[5]);
    set_ptr(8'h05, aa, as);
    chk(aa, "R1 write address acknowledged", aa, 1);
    chk(as, "R3 pointer byte acknowledged", as, 1);
    read_one(ra, d);
    chk(d == model[5], "R5 read after stop returns channel 5", d, model[5]);
    read_one(ra, d);
    chk(d == model[5], "R7 repeated read, no increment", d, model[5]);

    // R2: wrong strap bits, then a following byte must also be ignored
    bus_start();
    send_byte({5'b01011, 1'b0, 1'b1, 1'b0}, aa);
    chk(!aa, "R2 mismatched address not acknowledged", aa, 0);
    send_byte(8'h01, as);
    chk(!as, "R2 byte after mismatch ignored", as, 0);
    bus_stop();
    read_one(ra, d);
    chk(d == model[5], "R2 pointer unchanged after mismatch", d, model[5]);

    set_ptr(8'h0A, aa, as);
    chk(aa && !as, "R4 out-of-range pointer byte not acknowledged", {aa, as}, 2'b10);
    read_one(ra, d);
    chk(d == model[5], "R4 pointer unchanged after bad byte", d, model[5]);

    // R8: start in mid byte, then a clean pointer write
    begin
      logic s;
      bus_start();
      clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b0, s);
      set_ptr(8'h02, aa, as);
      chk(aa && as, "R8 restart mid byte then pointer write", {aa, as}, 2'b11);
      read_one(ra, d);
      chk(d == model[2], "R8 read after abandoned byte", d, model[2]);
      bus_start();
      clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b0, s);
      bus_stop();
      chk(sda_pull == 1'b0, "R8 stop mid byte releases SDA", sda_pull, 0);
      read_one(ra, d);
      chk(ra && d == model[2], "R8 read after stop mid byte", d, model[2]);
    end

    // R6: controller acks and keeps clocking; only one byte comes out
    bus_start();
    send_byte({5'b01011, a1, a0, 1'b1}, ra);
    recv_byte(1'b1, d);
    recv_byte(1'b0, d2);
    bus_stop();
    chk(d == model[2], "R6 first byte is channel 2", d, model[2]);
    chk(d2 == 8'hFF, "R6 second byte left released", d2, 8'hFF);
    chk(sda_pull == 1'b0, "R6 released after stop", sda_pull, 0);

    for (int it = 0; it < 24; it++) begin
      logic [2:0] ch;
      logic [6:0] badaddr;
      a1 = 1'($urandom); a0 = 1'($urandom);
      if (($urandom % 3) == 0) preload(3'($urandom), 8'($urandom));
      ch = 3'($urandom);
      set_ptr({5'b00000, ch}, aa, as);
      chk(aa && as, "R3 random pointer write acknowledged", {aa, as}, 2'b11);
      read_one(ra, d);
      chk(d == model[ch], "R5 random channel read", d, model[ch]);
      badaddr = 7'($urandom);
      bus_start();
      send_byte({badaddr, 1'b1}, ra);
      chk(ra == addr_ok(badaddr, a1, a0), "R1 random address decode", ra, addr_ok(badaddr, a1, a0));
      if (ra) begin
        recv_byte(1'b0, d);
        chk(d == model[ch], "R7 pointer kept for random address read", d, model[ch]);
      end
      bus_stop();
    end

    chk(viol == 0, "R9 SDA drive changed with SCL high", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule